// File: doc/BRIEF.md
# Configurable Registered Logic Macrocell

This block is a single output cell of a programmable logic array. A sum-of-products term and a second auxiliary term feed one storage element. Configuration inputs make that element a D, T, JK or SR flip-flop, a transparent latch, or a plain combinational path. Separate control terms provide clock enable, asynchronous set, asynchronous clear, synchronous set, latch enable and output enable. The cell clock is taken from the dedicated clock pin or from a product-term clock, as a configuration bit selects.

The cell drives a pad model made of an output data signal and an output enable signal. It also returns one feedback signal to the array. That signal is the cell output, the pad input or the buried register. The buried register keeps clocking the sum term as a D flip-flop when the cell is combinational, so registered state stays available on feedback while the pad shows logic.

Top module: `logic_macrocell`

## Requirements
- R1: While `rst_ni` is low, the register and the latch are 0, and `pin_data_o` is 0 in every register or latch mode.
- R2: Mode code 0 is a D flip-flop: on the active cell clock edge it loads `sop_i` when `ce_i` is 1 and holds when `ce_i` is 0. Codes 6 and 7 behave as code 0.
- R3: Mode code 1 is a T flip-flop: with `ce_i` at 1 it inverts its state on the clock edge when `sop_i` is 1 and holds when it is 0.
- R4: Mode code 2 is a JK flip-flop with J on `sop_i` and K on `aux_i`: J=K=0 holds, J=1 K=0 sets, J=0 K=1 clears, J=K=1 toggles.
- R5: Mode code 3 is an SR flip-flop with S on `sop_i` and R on `aux_i`: S alone sets, R alone clears, and S=R=1 or S=R=0 holds.
- R6: `ar_i` high forces the register and latch to 0 at once, without a clock; `ap_i` high forces them to 1 at once; with both high the result is 0. This holds in every mode except that code 5 drives `pin_data_o` from `sop_i`.
- R7: `sp_i` high at a clock edge loads 1 in modes 0, 1, 2, 3, 5, 6 and 7, regardless of `ce_i` and the data terms; the asynchronous controls take precedence over it. In latch mode it has no effect.
- R8: Mode code 4 is a latch: while `le_i` is 1 the output follows `sop_i`, while `le_i` is 0 it holds; the latch ignores the clock.
- R9: Mode code 5 drives `pin_data_o` directly from `sop_i`, while the buried register still loads `sop_i` as a D flip-flop with `ce_i` and `sp_i`.
- R10: `fb_sel_i` picks `fb_o`: code 0 and code 3 give `pin_data_o`, code 1 gives `pin_i`, code 2 gives the buried register value including asynchronous forcing.
- R11: `clk_sel_i` at 0 clocks the cell from `clk_i`; at 1 it clocks the cell from rising edges of `pt_clk_i`, and `clk_i` edges then have no effect.
- R12: `pin_oe_o` follows `oe_i` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dedicated clock pin |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pt_clk_i | input | 1 | Product-term clock |
| clk_sel_i | input | 1 | Clock source select, 1 = product-term clock |
| mode_i | input | 3 | Storage element mode code |
| fb_sel_i | input | 2 | Feedback source code |
| sop_i | input | 1 | Sum-of-products data term (D, T, J, S, latch data) |
| aux_i | input | 1 | Auxiliary term (K or R) |
| ce_i | input | 1 | Clock enable term, tie to 1 when unused |
| sp_i | input | 1 | Synchronous set term |
| ap_i | input | 1 | Asynchronous set term |
| ar_i | input | 1 | Asynchronous clear term |
| le_i | input | 1 | Latch enable term |
| oe_i | input | 1 | Output enable term |
| pin_i | input | 1 | Value read back from the pad |
| pin_data_o | output | 1 | Data to the pad driver |
| pin_oe_o | output | 1 | Enable to the pad driver |
| fb_o | output | 1 | Feedback to the array |

## Verification
The bench aims at precedence: both asynchronous terms together, clear released while set is held, and synchronous set against a low clock enable. A cell that let set win, waited for a clock to apply forcing, or gated set with the enable would show the wrong pad value in the same or next cycle. JK and SR with both terms high separate toggle from hold; a mix-up flips or freezes the state. Latch hold with changing data, buried feedback in combinational mode, and the product-term clock catch a latch that leaks, a register that stops in bypass, and a clock mux that still listens to the pin clock.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int MODE_W = 3;
  localparam int FB_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4,
    MODE_COMB  = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } cell_mode_e;

  typedef enum logic [FB_W-1:0] {
    FB_CELL   = 2'd0,
    FB_PIN    = 2'd1,
    FB_BURIED = 2'd2,
    FB_RSV    = 2'd3
  } fb_src_e;
endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_pkg::*;
(
  input  cell_mode_e mode_i,
  input  logic       q_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       ce_i,
  input  logic       sp_i,
  output logic       nxt_o
);
  always_comb begin
    nxt_o = q_i;
    if (mode_i == MODE_LATCH) begin
      nxt_o = q_i;
    end else if (sp_i) begin
      nxt_o = 1'b1;
    end else if (ce_i) begin
      unique case (mode_i)
        MODE_T:  nxt_o = q_i ^ a_i;
        MODE_JK: nxt_o = (a_i & ~q_i) | (~b_i & q_i);
        MODE_SR: begin
          unique case ({a_i, b_i})
            2'b10:   nxt_o = 1'b1;
            2'b01:   nxt_o = 1'b0;
            default: nxt_o = q_i;
          endcase
        end
        default: nxt_o = a_i;
      endcase
    end
  end
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ar_i,
  input  logic ap_i,
  input  logic le_i,
  input  logic d_i,
  input  logic nxt_i,
  output logic reg_q_o,
  output logic lat_q_o
);
  logic q_r;

  always_ff @(posedge clk_i or negedge rst_ni or posedge ar_i or posedge ap_i) begin
    if (!rst_ni)   q_r <= 1'b0;
    else if (ar_i) q_r <= 1'b0;
    else if (ap_i) q_r <= 1'b1;
    else           q_r <= nxt_i;
  end

  // level override: forcing stays visible while a term is held, even after the other releases
  assign reg_q_o = (!rst_ni || ar_i) ? 1'b0 : (ap_i ? 1'b1 : q_r);

  always_latch begin
    if (!rst_ni)   lat_q_o <= 1'b0;
    else if (ar_i) lat_q_o <= 1'b0;
    else if (ap_i) lat_q_o <= 1'b1;
    else if (le_i) lat_q_o <= d_i;
  end

  AST_LATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_i |-> (!lat_q_o && !reg_q_o)) else $error("async clear not applied"); // R6
endmodule

// File: rtl/mc_fb_mux.sv
module mc_fb_mux
  import mc_pkg::*;
(
  input  fb_src_e sel_i,
  input  logic    cell_i,
  input  logic    pin_i,
  input  logic    buried_i,
  output logic    fb_o
);
  always_comb begin
    unique case (sel_i)
      FB_PIN:    fb_o = pin_i;
      FB_BURIED: fb_o = buried_i;
      default:   fb_o = cell_i;
    endcase
  end
endmodule

// File: rtl/logic_macrocell.sv
module logic_macrocell
  import mc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pt_clk_i,
  input  logic              clk_sel_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [FB_W-1:0]   fb_sel_i,
  input  logic              sop_i,
  input  logic              aux_i,
  input  logic              ce_i,
  input  logic              sp_i,
  input  logic              ap_i,
  input  logic              ar_i,
  input  logic              le_i,
  input  logic              oe_i,
  input  logic              pin_i,
  output logic              pin_data_o,
  output logic              pin_oe_o,
  output logic              fb_o
);
  cell_mode_e mode;
  logic       cell_clk;
  logic       reg_q;
  logic       lat_q;
  logic       nxt;

  assign mode     = cell_mode_e'(mode_i);
  assign cell_clk = clk_sel_i ? pt_clk_i : clk_i;

  mc_next_state u_next (
    .mode_i (mode),
    .q_i    (reg_q),
    .a_i    (sop_i),
    .b_i    (aux_i),
    .ce_i   (ce_i),
    .sp_i   (sp_i),
    .nxt_o  (nxt)
  );

  mc_store u_store (
    .clk_i   (cell_clk),
    .rst_ni  (rst_ni),
    .ar_i    (ar_i),
    .ap_i    (ap_i),
    .le_i    (le_i),
    .d_i     (sop_i),
    .nxt_i   (nxt),
    .reg_q_o (reg_q),
    .lat_q_o (lat_q)
  );

  always_comb begin
    unique case (mode)
      MODE_COMB:  pin_data_o = sop_i;
      MODE_LATCH: pin_data_o = lat_q;
      default:    pin_data_o = reg_q;
    endcase
  end

  assign pin_oe_o = oe_i;

  mc_fb_mux u_fb (
    .sel_i    (fb_src_e'(fb_sel_i)),
    .cell_i   (pin_data_o),
    .pin_i    (pin_i),
    .buried_i (reg_q),
    .fb_o     (fb_o)
  );

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ar_i && mode != MODE_COMB) |-> !pin_data_o) else $error("clear not dominant"); // R6
  AST_SET_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_i && !ar_i && mode != MODE_COMB) |-> pin_data_o) else $error("set not applied"); // R6
  AST_COMB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_COMB) |-> (pin_data_o == sop_i)) else $error("bypass broken"); // R9
  AST_SYNC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni || ar_i || ap_i)
    (sp_i && !clk_sel_i && mode != MODE_LATCH && mode != MODE_COMB) |=> pin_data_o)
    else $error("sync set lost"); // R7
  AST_FB_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i == FB_PIN) |-> (fb_o == pin_i)) else $error("pin feedback wrong"); // R10
endmodule

// File: tb/logic_macrocell_test.sv
module logic_macrocell_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pt_clk_i = 1'b0;
  logic       clk_sel_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [1:0] fb_sel_i = 2'd0;
  logic       sop_i = 1'b0, aux_i = 1'b0, ce_i = 1'b0, sp_i = 1'b0;
  logic       ap_i = 1'b0, ar_i = 1'b0, le_i = 1'b0, oe_i = 1'b0, pin_i = 1'b0;
  logic       pin_data_o, pin_oe_o, fb_o;

  int checks = 0;
  int failures = 0;
  logic mq = 1'b0;
  logic ml = 1'b0;

  logic_macrocell uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic nxt_f(logic [2:0] m, logic q, logic a, logic b, logic c, logic s);
    if (m == 3'd4) return q;
    if (s) return 1'b1;
    if (!c) return q;
    case (m)
      3'd1: return q ^ a;
      3'd2: return a ? (b ? ~q : 1'b1) : (b ? 1'b0 : q);
      3'd3: return (a && !b) ? 1'b1 : ((!a && b) ? 1'b0 : q);
      default: return a;
    endcase
  endfunction

  function automatic logic exp_pin();
    if (mode_i == 3'd5) return sop_i;
    if (mode_i == 3'd4) return ml;
    return mq;
  endfunction

  function automatic logic exp_fb();
    if (fb_sel_i == 2'd1) return pin_i;
    if (fb_sel_i == 2'd2) return mq;
    return exp_pin();
  endfunction

  function automatic string tag_for();
    if ((ar_i || ap_i) && mode_i != 3'd5) return "R6";
    case (mode_i)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic model_async();
    if (ar_i) mq = 1'b0; else if (ap_i) mq = 1'b1;
    if (ar_i) ml = 1'b0; else if (ap_i) ml = 1'b1; else if (le_i) ml = sop_i;
  endtask

  task automatic cycle(logic [2:0] m, logic [1:0] f, logic s, logic a, logic c, logic p,
                       logic pre, logic clr, logic l, logic o, logic pn);
    @(negedge clk_i);
    mode_i = m; fb_sel_i = f; aux_i = a; ce_i = c; sp_i = p;
    ap_i = pre; ar_i = clr; le_i = l; oe_i = o; pin_i = pn;
    #1 sop_i = s;
    #1 model_async();
    check(tag_for(), pin_data_o, exp_pin(), "pin_data");
    check("R10", fb_o, exp_fb(), "feedback");
    check("R12", pin_oe_o, oe_i, "pin_oe");
    @(posedge clk_i);
    if (!clk_sel_i) begin
      if (ar_i) mq = 1'b0;
      else if (ap_i) mq = 1'b1;
      else mq = nxt_f(mode_i, mq, sop_i, aux_i, ce_i, sp_i);
    end
  endtask

  task automatic peek(string tag, logic exp);
    #1 check(tag, pin_data_o, exp, "after edge");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk_i);
    ap_i = 1'b1; sop_i = 1'b1; ce_i = 1'b1; le_i = 1'b1;
    #1;
    check("R1", pin_data_o, 1'b0, "reset D mode");
    fb_sel_i = 2'd2; #1;
    check("R1", fb_o, 1'b0, "reset buried");
    mode_i = 3'd4; #1;
    check("R1", pin_data_o, 1'b0, "reset latch");
    @(negedge clk_i);
    ap_i = 1'b0; sop_i = 1'b0; ce_i = 1'b0; le_i = 1'b0; mode_i = 3'd0; fb_sel_i = 2'd0;
    rst_ni = 1'b1;

    // R2 load and hold
    cycle(3'd0, 2'd0, 1, 0, 1, 0, 0, 0, 0, 1, 0); peek("R2", 1'b1);
    cycle(3'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 0); peek("R2", 1'b1);
    // R7 sync set beats low CE and zero data
    cycle(3'd0, 2'd0, 0, 0, 1, 0, 0, 1, 0, 0, 0); peek("R2", 1'b0);
    cycle(3'd0, 2'd0, 0, 0, 0, 1, 0, 0, 0, 0, 0); peek("R7", 1'b1);
    // R6 both async, then clear released with set held
    cycle(3'd0, 2'd2, 0, 0, 1, 0, 1, 1, 0, 0, 0);
    cycle(3'd0, 2'd2, 0, 0, 1, 0, 1, 0, 0, 0, 0); peek("R6", 1'b1);
    // R3 toggle
    cycle(3'd1, 2'd0, 1, 0, 1, 0, 0, 0, 0, 0, 0); peek("R3", 1'b0);
    cycle(3'd1, 2'd0, 1, 0, 1, 0, 0, 0, 0, 0, 0); peek("R3", 1'b1);
    // R4 J=K=1 toggles
    cycle(3'd2, 2'd0, 1, 1, 1, 0, 0, 0, 0, 0, 0); peek("R4", 1'b0);
    cycle(3'd2, 2'd0, 1, 1, 1, 0, 0, 0, 0, 0, 0); peek("R4", 1'b1);
    // R5 S=R=1 holds
    cycle(3'd3, 2'd0, 1, 1, 1, 0, 0, 0, 0, 0, 0); peek("R5", 1'b1);
    cycle(3'd3, 2'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0); peek("R5", 1'b0);
    cycle(3'd3, 2'd0, 1, 1, 1, 0, 0, 0, 0, 0, 0); peek("R5", 1'b0);
    // R8 latch transparent then hold
    cycle(3'd4, 2'd0, 1, 0, 1, 0, 0, 0, 1, 0, 0);
    cycle(3'd4, 2'd0, 0, 0, 1, 1, 0, 0, 0, 0, 0); peek("R8", 1'b1);
    // R9 bypass with buried register
    cycle(3'd5, 2'd2, 1, 0, 1, 0, 0, 0, 0, 0, 0); peek("R9", 1'b1);
    cycle(3'd5, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    #1 check("R9", fb_o, 1'b1, "buried keeps register");

    // R11 product-term clock
    cycle(3'd0, 2'd0, 0, 0, 1, 0, 0, 1, 0, 0, 0);
    @(negedge clk_i);
    clk_sel_i = 1'b1; ar_i = 1'b0; sop_i = 1'b1; ce_i = 1'b1;
    @(posedge clk_i); #1;
    check("R11", pin_data_o, 1'b0, "pin clock ignored");
    pt_clk_i = 1'b1; #1 pt_clk_i = 1'b0; #1;
    check("R11", pin_data_o, 1'b1, "pt clock loads");
    mq = 1'b1;
    @(negedge clk_i);
    clk_sel_i = 1'b0;

    for (int b = 0; b < 12; b++) begin
      logic [2:0] m;
      logic [1:0] f;
      m = 3'($urandom_range(0, 7));
      f = 2'($urandom_range(0, 3));
      for (int i = 0; i < 30; i++) begin
        cycle(m, f, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 3) != 0),
              (i < 29) && ($urandom_range(0, 7) == 0),
              $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
    end
    report();
  end
endmodule